// File: doc/BRIEF.md
# Egress Packet Checksum Verifier

This block sits on the path from the switch fabric toward the transmit MACs. Each packet arrives as a stream of beats. The first beat is a header word that carries a 16-bit packet checksum, written by the ingress stage, and the index of the egress port. The verifier removes the header and passes the data beats on unchanged. While the data streams past, it builds a verification checksum with the same ones'-complement algorithm that the ingress stage used. When it accepts the final beat, it compares the two checksums.

A packet whose checksums disagree is still forwarded. Its end-of-packet beat carries an error flag, so that downstream logic can choose to abort it. Each egress port has its own saturating error counter. A read port returns the count of any selected port in the same cycle, and a per-port clear sets a count back to zero. Input and output use a valid/ready handshake. Back-to-back packets stream at full rate, and the output holds still while the downstream side stalls.

Top module: `egress_cksum_verifier`

## Requirements
- R1: The first beat of each packet is a header. Bits 15:0 hold the packet checksum and bits 16 upward (3 bits for 8 ports) hold the egress port. The header is never forwarded. The data bytes leave in arrival order, and `out_port` carries the header's port.
- R2: The verification checksum is the 16-bit ones'-complement sum (end-around carry) of the data taken as 16-bit words. The earlier byte of each pair forms the high half of its word. Within a beat, lane 3 (`data[31:24]`, `keep[3]`) is the earliest byte, and `keep` is contiguous from lane 3 down. A lone final byte is padded with a zero low byte.
- R3: A packet matches when the verification checksum equals the header checksum. It also matches when each of the two values is either 0x0000 or 0xFFFF.
- R4: `out_err` is 1 only on the final beat of a packet that does not match. That packet is still forwarded in full.
- R5: A mismatch adds exactly one to the count of that packet's port. The new count appears on `rd_count` in the cycle after the final beat is accepted. The counts of other ports do not change.
- R6: Counters saturate at all-ones and never wrap.
- R7: A pulse on `clr_valid` zeroes the count of `clr_port`. If an increment for that port falls in the same cycle, the clear wins and the count reads 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field stays stable.
- R9: `in_ready` is 1 whenever the output register is empty or being drained, and also while a header is expected. A continuous stream of packets is therefore accepted with no idle input cycles.
- R10: After reset, `out_valid` is 0, every count is 0 and the next beat is taken as a header.
- R11: `rd_count` shows the count of the port selected by `rd_port` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Header word or packet data |
| in_keep | input | DATA_W/8 | Byte-lane enables, lane 3 earliest |
| in_last | input | 1 | Final data beat of the packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Forwarded packet data |
| out_keep | output | DATA_W/8 | Forwarded byte-lane enables |
| out_last | output | 1 | Final beat of the packet |
| out_err | output | 1 | Checksum mismatch, on the final beat only |
| out_port | output | log2(NPORTS) | Egress port of the packet |
| clr_valid | input | 1 | Clear pulse for one counter |
| clr_port | input | log2(NPORTS) | Port whose counter is cleared |
| rd_port | input | log2(NPORTS) | Port whose counter is read |
| rd_count | output | CNT_W | Error count of rd_port |

## Verification
Two functions can collide on one counter in a single cycle: a clear and a mismatch increment for the same port. The bench provokes this by holding `clr_valid` for a port in the very cycle that port's corrupted final beat is accepted. It first gives that port a nonzero count. The collision passes only if the read afterwards shows 0 rather than 1 or 2. Output holding can also coincide with a header being accepted; randomized downstream stalls exercise this while the forwarded bytes are compared against the bench model.

// File: rtl/ecv_pkg.sv
package ecv_pkg;

  localparam int CK_W = 16;

  // ones'-complement 16-bit addition with end-around carry
  function automatic logic [CK_W-1:0] oc_add(input logic [CK_W-1:0] a,
                                             input logic [CK_W-1:0] b);
    logic [CK_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CK_W-1:0] + {{(CK_W-1){1'b0}}, s[CK_W]};
  endfunction

  // both encodings of ones'-complement zero
  function automatic logic is_zero_code(input logic [CK_W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

endpackage

// File: rtl/ecv_beat_sum.sv
module ecv_beat_sum
  import ecv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   data,
  input  logic [DATA_W/8-1:0] keep,
  output logic [CK_W-1:0]     sum
);

  localparam int KW = DATA_W / 8;
  localparam int NW = DATA_W / CK_W;

  logic [DATA_W-1:0] masked;

  // zero the byte lanes that carry no data (gives odd-byte padding)
  always_comb begin
    for (int b = 0; b < KW; b++) begin
      masked[8*b +: 8] = keep[b] ? data[8*b +: 8] : 8'h00;
    end
  end

  // fold every 16-bit word of the beat, most significant word first
  always_comb begin
    sum = '0;
    for (int w = 0; w < NW; w++) begin
      sum = oc_add(sum, masked[DATA_W-1-CK_W*w -: CK_W]);
    end
  end

endmodule

// File: rtl/ecv_frame_ctl.sv
module ecv_frame_ctl
  import ecv_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_fire,
  input  logic            beat_last,
  input  logic [CK_W-1:0] hdr_ck,
  input  logic [PW-1:0]   hdr_port,
  input  logic [CK_W-1:0] beat_sum,
  output logic            expect_hdr,
  output logic [PW-1:0]   pkt_port,
  output logic            pkt_bad
);

  logic            hdr_q, hdr_d;
  logic [CK_W-1:0] ck_q, ck_d;
  logic [PW-1:0]   port_q, port_d;
  logic [CK_W-1:0] acc_q, acc_d;
  logic [CK_W-1:0] total;
  logic            match;

  assign total = oc_add(acc_q, beat_sum);
  assign match = (total == ck_q) || (is_zero_code(total) && is_zero_code(ck_q));

  always_comb begin
    hdr_d  = hdr_q;
    ck_d   = ck_q;
    port_d = port_q;
    acc_d  = acc_q;
    if (beat_fire) begin
      if (hdr_q) begin
        hdr_d  = 1'b0;
        ck_d   = hdr_ck;
        port_d = hdr_port;
        acc_d  = '0;
      end else begin
        acc_d = total;
        if (beat_last) begin
          hdr_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= 1'b1;
      ck_q   <= '0;
      port_q <= '0;
      acc_q  <= '0;
    end else if (beat_fire) begin
      hdr_q  <= hdr_d;
      ck_q   <= ck_d;
      port_q <= port_d;
      acc_q  <= acc_d;
    end
  end

  assign expect_hdr = hdr_q;
  assign pkt_port   = port_q;
  assign pkt_bad    = ~match;

endmodule

// File: rtl/ecv_out_stage.sv
module ecv_out_stage #(
  parameter int DATA_W = 32,
  parameter int PW     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic [DATA_W/8-1:0] ld_keep,
  input  logic                ld_last,
  input  logic                ld_err,
  input  logic [PW-1:0]       ld_port,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W/8-1:0] out_keep,
  output logic                out_last,
  output logic                out_err,
  output logic [PW-1:0]       out_port
);

  localparam int KW = DATA_W / 8;

  logic              v_q, v_d;
  logic [DATA_W-1:0] d_q;
  logic [KW-1:0]     k_q;
  logic              l_q;
  logic              e_q;
  logic [PW-1:0]     p_q;

  always_comb begin
    v_d = v_q;
    if (load) begin
      v_d = 1'b1;
    end else if (out_ready) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      k_q <= '0;
      l_q <= 1'b0;
      e_q <= 1'b0;
      p_q <= '0;
    end else if (load) begin
      d_q <= ld_data;
      k_q <= ld_keep;
      l_q <= ld_last;
      e_q <= ld_err;
      p_q <= ld_port;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
  assign out_keep  = k_q;
  assign out_last  = l_q;
  assign out_err   = e_q;
  assign out_port  = p_q;

endmodule

// File: rtl/ecv_cnt_bank.sv
module ecv_cnt_bank #(
  parameter int NPORTS = 8,
  parameter int CNT_W  = 32,
  parameter int PW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [PW-1:0]    inc_port,
  input  logic             clr,
  input  logic [PW-1:0]    clr_port,
  input  logic [PW-1:0]    rd_port,
  output logic [CNT_W-1:0] rd_count
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [CNT_W-1:0] cnt_d;
    logic             hit_clr;
    logic             hit_inc;

    assign hit_clr = clr & (clr_port == PW'(p));
    assign hit_inc = inc & (inc_port == PW'(p)) & (cnt_q[p] != CMAX);

    always_comb begin
      cnt_d = cnt_q[p];
      if (hit_clr) begin
        cnt_d = '0;
      end else if (hit_inc) begin
        cnt_d = cnt_q[p] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[p] <= '0;
      end else if (hit_clr | hit_inc) begin
        cnt_q[p] <= cnt_d;
      end
    end
  end

  assign rd_count = cnt_q[rd_port];

endmodule

// File: rtl/egress_cksum_verifier.sv
module egress_cksum_verifier
  import ecv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPORTS = 8,
  parameter int CNT_W  = 32,
  localparam int KW    = DATA_W / 8,
  localparam int PW    = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [KW-1:0]     in_keep,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [KW-1:0]     out_keep,
  output logic              out_last,
  output logic              out_err,
  output logic [PW-1:0]     out_port,
  input  logic              clr_valid,
  input  logic [PW-1:0]     clr_port,
  input  logic [PW-1:0]     rd_port,
  output logic [CNT_W-1:0]  rd_count
);

  logic            expect_hdr;
  logic            beat_fire;
  logic            data_fire;
  logic            pkt_end;
  logic            pkt_bad;
  logic [PW-1:0]   pkt_port;
  logic [CK_W-1:0] beat_sum;

  assign in_ready  = expect_hdr | ~out_valid | out_ready;
  assign beat_fire = in_valid & in_ready;
  assign data_fire = beat_fire & ~expect_hdr;
  assign pkt_end   = data_fire & in_last;

  ecv_beat_sum #(
    .DATA_W(DATA_W)
  ) u_sum (
    .data (in_data),
    .keep (in_keep),
    .sum  (beat_sum)
  );

  ecv_frame_ctl #(
    .PW(PW)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (beat_fire),
    .beat_last  (in_last),
    .hdr_ck     (in_data[CK_W-1:0]),
    .hdr_port   (in_data[CK_W +: PW]),
    .beat_sum   (beat_sum),
    .expect_hdr (expect_hdr),
    .pkt_port   (pkt_port),
    .pkt_bad    (pkt_bad)
  );

  ecv_out_stage #(
    .DATA_W(DATA_W),
    .PW    (PW)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_fire),
    .ld_data   (in_data),
    .ld_keep   (in_keep),
    .ld_last   (in_last),
    .ld_err    (pkt_end & pkt_bad),
    .ld_port   (pkt_port),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last),
    .out_err   (out_err),
    .out_port  (out_port)
  );

  ecv_cnt_bank #(
    .NPORTS(NPORTS),
    .CNT_W (CNT_W),
    .PW    (PW)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (pkt_end & pkt_bad),
    .inc_port (pkt_port),
    .clr      (clr_valid),
    .clr_port (clr_port),
    .rd_port  (rd_port),
    .rd_count (rd_count)
  );

endmodule

// File: rtl/ecv_checker.sv
module ecv_checker #(
  parameter int DATA_W = 32,
  parameter int NPORTS = 8,
  parameter int CNT_W  = 32,
  localparam int KW    = DATA_W / 8,
  localparam int PW    = $clog2(NPORTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [KW-1:0]     out_keep,
  input logic              out_last,
  input logic              out_err,
  input logic [PW-1:0]     out_port,
  input logic              clr_valid,
  input logic [PW-1:0]     clr_port,
  input logic [PW-1:0]     rd_port,
  input logic [CNT_W-1:0]  rd_count
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep)
      && $stable(out_last) && $stable(out_err) && $stable(out_port)); // R8

  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last); // R4

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_valid) && rd_port == $past(clr_port) |-> rd_count == '0); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_valid) && rd_port == $past(rd_port)
      |-> (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + 1'b1)); // R5

  AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_valid) && rd_port == $past(rd_port) |-> rd_count >= $past(rd_count)); // R6

endmodule

bind egress_cksum_verifier ecv_checker #(
  .DATA_W(DATA_W),
  .NPORTS(NPORTS),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/egress_cksum_verifier_test.sv
module egress_cksum_verifier_test;

  localparam int CW = 4;
  localparam logic [CW-1:0] SAT = '1;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [3:0]  in_keep;
  logic        in_last;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last;
  logic        out_err;
  logic [2:0]  out_port;
  logic        clr_valid;
  logic [2:0]  clr_port;
  logic [2:0]  rd_port;
  logic [CW-1:0] rd_count;

  egress_cksum_verifier #(.DATA_W(32), .NPORTS(8), .CNT_W(CW)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model and observation
  logic [7:0] pb [64];
  logic [7:0] exp_b [$];
  logic [7:0] got_b [$];
  bit         exp_e [$];
  bit         got_e [$];
  logic [2:0] exp_p [$];
  logic [2:0] got_p [$];
  int         model_cnt [8];
  bit         stall_mode = 0;
  bit         watch_stall = 0;
  int         stall_seen = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor, sampled just before the rising edge
  always begin
    @(negedge clk);
    #8;
    if (rst_n && watch_stall && in_valid && !in_ready) stall_seen++;
    if (rst_n && out_valid && out_ready) begin
      for (int l = 3; l >= 0; l--) if (out_keep[l]) got_b.push_back(out_data[8*l +: 8]);
      if (out_last) begin
        got_e.push_back(out_err);
        got_p.push_back(out_port);
      end else if (out_err) begin
        chk(0, "R4 err off last beat", 1, 0);
      end
    end
  end

  function automatic logic [15:0] ref_sum(input int len);
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < len; i += 2) s += {pb[i], (i + 1 < len) ? pb[i+1] : 8'h00};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic bit zc(input logic [15:0] v);
    return v == 16'h0000 || v == 16'hFFFF;
  endfunction

  task automatic push_beat(input logic [31:0] d, input logic [3:0] k, input logic l, input bit c,
                           input logic [2:0] cp);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_keep = k; in_last = l;
    clr_valid = c; clr_port = cp;
    #9;
    while (!in_ready) #20;
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; clr_valid = 1'b0;
  endtask

  // send pb[0:len-1] to a port; hdr is the header checksum
  task automatic send_pkt(input int port, input int len, input logic [15:0] hdr, input bit clr_last);
    logic [15:0] s;
    bit bad;
    s = ref_sum(len);
    bad = !(s == hdr || (zc(s) && zc(hdr)));
    for (int i = 0; i < len; i++) exp_b.push_back(pb[i]);
    exp_e.push_back(bad);
    exp_p.push_back(3'(port));
    push_beat({13'h1ABC, 3'(port), hdr}, 4'hF, 1'b0, 1'b0, 3'd0);
    for (int i = 0; i < len; i += 4) begin
      logic [31:0] d;
      logic [3:0]  k;
      bit          lst;
      d = 32'h0; k = 4'h0;
      for (int j = 0; j < 4; j++) if (i + j < len) begin
        d[31-8*j -: 8] = pb[i+j];
        k[3-j] = 1'b1;
      end
      lst = (i + 4 >= len);
      push_beat(d, k, lst, lst && clr_last, 3'(port));
    end
    if (bad && !clr_last && model_cnt[port] < int'(SAT)) model_cnt[port]++;
    if (clr_last) model_cnt[port] = 0;
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) pb[i] = 8'((seed * 37 + i * 91 + 13) ^ (i << 2));
  endtask

  task automatic drain_and_compare(input string rq);
    go_idle();
    stall_mode = 0;
    repeat (6) @(negedge clk);
    chk(got_b.size() == exp_b.size(), {rq, " byte count"}, got_b.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
      chk(got_b[i] == exp_b[i], {rq, " data byte"}, got_b[i], exp_b[i]);
    chk(got_e.size() == exp_e.size(), {rq, " packet count"}, got_e.size(), exp_e.size());
    for (int i = 0; i < exp_e.size() && i < got_e.size(); i++) begin
      chk(got_e[i] == exp_e[i], "R4 err flag on last beat", got_e[i], exp_e[i]);
      chk(got_p[i] == exp_p[i], "R1 out_port", got_p[i], exp_p[i]);
    end
    exp_b.delete(); got_b.delete(); exp_e.delete(); got_e.delete();
    exp_p.delete(); got_p.delete();
  endtask

  task automatic check_counts(input string rq);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      rd_port = 3'(p);
      #2;
      chk(rd_count == CW'(model_cnt[p]), rq, rd_count, model_cnt[p]);
    end
  endtask

  // R10: reset state
  task automatic t_reset();
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check_counts("R10 R11 count after reset");
  endtask

  // R1 R2: good packets, even and odd lengths
  task automatic t_good();
    fill(8, 1);  send_pkt(2, 8, ref_sum(8), 0);
    fill(7, 2);  send_pkt(0, 7, ref_sum(7), 0);
    fill(1, 3);  send_pkt(6, 1, ref_sum(1), 0);
    fill(13, 4); send_pkt(4, 13, ref_sum(13), 0);
    drain_and_compare("R1 R2 good packets");
    check_counts("R5 no count on good packets");
  endtask

  // R4 R5: corrupted packets still forwarded and counted per port
  task automatic t_bad();
    fill(7, 5);  send_pkt(5, 7, ref_sum(7) ^ 16'h0101, 0);
    fill(10, 6); send_pkt(1, 10, ref_sum(10) + 16'h0003, 0);
    fill(4, 7);  send_pkt(5, 4, ~ref_sum(4), 0);
    drain_and_compare("R4 forwarding bad packets");
    check_counts("R5 per-port counts");
  endtask

  // R3: zero-code equivalence
  task automatic t_zero();
    for (int i = 0; i < 4; i++) pb[i] = 8'h00;
    send_pkt(3, 4, 16'hFFFF, 0);
    pb[0] = 8'hFF; pb[1] = 8'hFF; pb[2] = 8'h00; pb[3] = 8'h00;
    send_pkt(3, 4, 16'h0000, 0);
    pb[0] = 8'hFF; pb[1] = 8'hFE;
    send_pkt(3, 2, 16'hFFFF, 0);
    drain_and_compare("R3 zero codes");
    check_counts("R3 zero codes count");
  endtask

  // R8: downstream stalls with back-to-back packets
  task automatic t_stall();
    stall_mode = 1;
    for (int n = 0; n < 6; n++) begin
      int len;
      len = 3 + n * 5;
      fill(len, 20 + n);
      send_pkt(n, len, (n % 2 == 1) ? ref_sum(len) ^ 16'h8000 : ref_sum(len), 0);
    end
    drain_and_compare("R8 under backpressure");
    check_counts("R8 R5 counts after stalls");
  endtask

  // R9: full rate with no input stalls
  task automatic t_rate();
    stall_seen = 0;
    watch_stall = 1;
    for (int n = 0; n < 4; n++) begin
      fill(9, 40 + n);
      send_pkt(7 - n, 9, ref_sum(9), 0);
    end
    watch_stall = 0;
    chk(stall_seen == 0, "R9 input stall cycles", stall_seen, 0);
    drain_and_compare("R9 streaming");
  endtask

  // R7: plain clear and clear colliding with an increment
  task automatic t_clear();
    @(negedge clk); clr_valid = 1'b1; clr_port = 3'd5;
    @(negedge clk); clr_valid = 1'b0;
    model_cnt[5] = 0;
    check_counts("R7 clear port 5");
    fill(6, 60); send_pkt(3, 6, ref_sum(6) ^ 16'h0010, 0);
    drain_and_compare("R7 setup");
    @(negedge clk); rd_port = 3'd3; #2;
    chk(rd_count == CW'(model_cnt[3]), "R7 count before collision", rd_count, model_cnt[3]);
    fill(6, 61); send_pkt(3, 6, ref_sum(6) ^ 16'h0010, 1);
    drain_and_compare("R7 collision packet");
    check_counts("R7 clear wins over increment");
  endtask

  // R6: saturation
  task automatic t_sat();
    for (int n = 0; n < 18; n++) begin
      fill(2, 80 + n);
      send_pkt(7, 2, ref_sum(2) ^ 16'h0F00, 0);
    end
    drain_and_compare("R6 packets");
    @(negedge clk); rd_port = 3'd7; #2;
    chk(rd_count == SAT, "R6 saturated count", rd_count, SAT);
    check_counts("R6 R5 counts");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_keep = '0; in_last = 1'b0;
    clr_valid = 1'b0; clr_port = '0; rd_port = '0; out_ready = 1'b1;
    for (int p = 0; p < 8; p++) model_cnt[p] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_bad();
    t_zero();
    t_stall();
    t_rate();
    t_clear();
    t_sat();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule